// File: doc/BRIEF.md
# Low-Power Entry Wake-Up Keep-Out Gate

This block sits in front of a power controller's wake-up inputs while the chip moves into a low-power state. Software pulses a one-cycle entry trigger at the same moment it asks for the low-power state. The trigger starts a fixed keep-out window of at least 6 microseconds of real time. While the window runs, every wake-up line is blocked from the controller.

A wake-up that shows up during the window is not lost. It is caught in a per-line pending latch and driven to the controller as soon as the window closes. It stays there until the controller acknowledges that line. A wake-up that is simply still present when the window closes passes straight through. Each asynchronous wake-up line is first brought into the clock domain by a synchronizer of at least two flops.

The window length in clock cycles comes from the clock frequency and the keep-out time. It is rounded up, so the window never falls short of the real-time limit.

Top module: `wk_keepout_gate`

## Requirements
- R1: While reset is high, and on the first cycle after it, `wake_o` is all zero and `keepout_o` is low. Reset also clears every pending latch.
- R2: A trigger sampled on `start_i` raises `keepout_o` on the next cycle. The flag then stays high for exactly WIN_CYC consecutive cycles and falls afterwards. WIN_CYC = ceil(CLK_HZ * KEEPOUT_NS / 1e9), which is 1200 at the defaults.
- R3: Every bit of `wake_o` is zero on every cycle in which `keepout_o` is high.
- R4: A wake-up that reaches the synchronizer output during a window is latched. From the first cycle after the window ends, it drives its `wake_o` bit high, even if the input has already returned low.
- R5: A wake-up input that is held high across the end of a window drives its `wake_o` bit high from the first cycle after the window ends.
- R6: Outside a window, a change on `wake_i[n]` appears on `wake_o[n]` three clock edges later: two synchronizer flops, then the output register. Outside a window, nothing is latched.
- R7: While a line's pending latch is set, a one-cycle pulse on `ack_i[n]` clears it. If `wake_i[n]` is low, `wake_o[n]` then falls on the next cycle.
- R8: A trigger that arrives while `keepout_o` is high restarts the count. The flag then stays high for WIN_CYC cycles after that second trigger.
- R9: An acknowledge on one line leaves the pending state and the output of every other line unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle trigger that starts or restarts the keep-out window |
| wake_i | input | N_WAKE | Asynchronous wake-up request lines |
| ack_i | input | N_WAKE | Per-line clear for a latched wake-up |
| wake_o | output | N_WAKE | Gated wake-up lines to the power controller (registered) |
| keepout_o | output | 1 | High exactly while the keep-out window runs (registered) |

## Verification
If the window counter holds a wrong value, `keepout_o` falls early or late. The behavioural model flags this on the cycle where the flag's length first differs, at the latest WIN_CYC cycles after the trigger.

If a pending latch is dropped or set by mistake, the fault stays hidden until the window closes. It then shows as a missing or extra `wake_o` bit on the first cycle after `keepout_o` falls.

A synchronizer of the wrong depth shifts every pass-through edge by one or more cycles. The model catches this on the first idle-time wake-up.

// File: rtl/wk_pkg.sv
package wk_pkg;
  // Keep-out cycles, rounded up so the window never falls short of real time.
  function automatic longint unsigned win_cycles(longint unsigned clk_hz,
                                                 longint unsigned window_ns);
    longint unsigned prod;
    prod = clk_hz * window_ns;
    return (prod + 64'd999_999_999) / 64'd1_000_000_000;
  endfunction
endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
  parameter int N_WAKE = 4,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_WAKE-1:0] async_i,
  output logic [N_WAKE-1:0] sync_o
);
  logic [N_WAKE-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= '0;
    end else begin
      chain[0] <= async_i;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/wk_window_timer.sv
module wk_window_timer #(
  parameter int unsigned WIN_CYC = 1200
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic act_next_o,
  output logic act_o
);
  localparam int CW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam logic [CW-1:0] LOAD = CW'(WIN_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (start_i) begin
      cnt_d = LOAD;
      act_d = 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) act_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign act_next_o = act_d;
  assign act_o      = act_q;
endmodule

// File: rtl/wk_pend_gate.sv
module wk_pend_gate #(
  parameter int N_WAKE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act_next_i,
  input  logic [N_WAKE-1:0] sync_i,
  input  logic [N_WAKE-1:0] ack_i,
  output logic [N_WAKE-1:0] wake_o
);
  for (genvar n = 0; n < N_WAKE; n++) begin : g_line
    logic held_q, held_d, out_q;

    always_comb held_d = (held_q & ~ack_i[n]) | (act_next_i & sync_i[n]);

    always_ff @(posedge clk) begin
      if (rst) begin
        held_q <= 1'b0;
        out_q  <= 1'b0;
      end else begin
        held_q <= held_d;
        out_q  <= ~act_next_i & (sync_i[n] | held_d);
      end
    end

    assign wake_o[n] = out_q;
  end
endmodule

// File: rtl/wk_keepout_gate.sv
module wk_keepout_gate #(
  parameter int unsigned N_WAKE      = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CLK_HZ      = 200_000_000,
  parameter int unsigned KEEPOUT_NS  = 6000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [N_WAKE-1:0] wake_i,
  input  logic [N_WAKE-1:0] ack_i,
  output logic [N_WAKE-1:0] wake_o,
  output logic              keepout_o
);
  localparam int unsigned WIN_CYC =
    int'(wk_pkg::win_cycles(longint'(CLK_HZ), longint'(KEEPOUT_NS)));

  logic [N_WAKE-1:0] wake_sync;
  logic              act_next;

  wk_sync #(.N_WAKE(N_WAKE), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(wake_i), .sync_o(wake_sync)
  );

  wk_window_timer #(.WIN_CYC(WIN_CYC)) u_timer (
    .clk(clk), .rst(rst), .start_i(start_i),
    .act_next_o(act_next), .act_o(keepout_o)
  );

  wk_pend_gate #(.N_WAKE(N_WAKE)) u_gate (
    .clk(clk), .rst(rst), .act_next_i(act_next),
    .sync_i(wake_sync), .ack_i(ack_i), .wake_o(wake_o)
  );
endmodule

// File: rtl/wk_keepout_gate_chk.sv
module wk_keepout_gate_chk #(
  parameter int unsigned N_WAKE  = 4,
  parameter int unsigned WIN_CYC = 1200
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [N_WAKE-1:0] wake_o,
  input logic              keepout_o
);
  localparam int RW = $clog2(WIN_CYC + 2);
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst)            run <= '0;
    else if (start_i)   run <= '0;
    else if (keepout_o) run <= run + 1'b1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (wake_o == '0 && !keepout_o));

  // R3
  blank_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    keepout_o |-> (wake_o == '0));

  // R2
  start_opens_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> keepout_o);

  // R2
  window_length_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(keepout_o) |-> (run == RW'(WIN_CYC)));

  // R8
  no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    keepout_o |-> (run < RW'(WIN_CYC)));
endmodule

bind wk_keepout_gate wk_keepout_gate_chk #(
  .N_WAKE(N_WAKE), .WIN_CYC(WIN_CYC)
) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i),
  .wake_o(wake_o), .keepout_o(keepout_o)
);

// File: tb/wk_keepout_gate_test.sv
`timescale 1ns/1ps
module wk_keepout_gate_test;
  localparam int N   = 4;
  localparam int SS  = 2;
  localparam int WIN = 1200;   // 200 MHz * 6 us

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [N-1:0] wake_i = '0;
  logic [N-1:0] ack_i = '0;
  logic [N-1:0] wake_o;
  logic         keepout_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  wk_keepout_gate #(.N_WAKE(N), .SYNC_STAGES(SS)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .wake_i(wake_i),
    .ack_i(ack_i), .wake_o(wake_o), .keepout_o(keepout_o)
  );

  // Behavioural reference model
  logic [N-1:0] m_pipe[$];
  logic [N-1:0] m_pend, m_wake;
  int           m_rem;
  logic         m_keep;

  always @(posedge clk) begin
    logic [N-1:0] cur;
    if (rst) begin
      m_pipe = {};
      for (int k = 0; k < SS; k++) m_pipe.push_back('0);
      m_pend = '0; m_wake = '0; m_rem = 0; m_keep = 1'b0;
    end else begin
      cur = m_pipe.pop_front();
      m_pipe.push_back(wake_i);
      if (start_i) m_rem = WIN;
      else if (m_rem > 0) m_rem = m_rem - 1;
      m_keep = (m_rem > 0);
      m_pend = (m_pend & ~ack_i) | (m_keep ? cur : '0);
      m_wake = m_keep ? '0 : (cur | m_pend);
    end
  end

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2/R8 keepout model", {{(N-1){1'b0}}, keepout_o}, {{(N-1){1'b0}}, m_keep});
      check("R3/R4/R5/R6/R7 wake model", wake_o, m_wake);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_i = 1'b1; tick(); start_i = 1'b0;
  endtask

  task automatic pulse_ack(logic [N-1:0] m);
    ack_i = m; tick(); ack_i = '0;
  endtask

  int len;

  initial begin
    tick(4);
    // R1
    check("R1 wake reset", wake_o, '0);
    check("R1 keepout reset", {{(N-1){1'b0}}, keepout_o}, '0);
    rst = 1'b0;
    tick(1);
    check("R1 wake after reset", wake_o, '0);

    // R6: pass-through latency of three edges
    wake_i = 4'b0001;
    tick(2);
    check("R6 not yet", wake_o, 4'b0000);
    tick(1);
    check("R6 passed", wake_o, 4'b0001);
    wake_i = '0;
    tick(3);
    check("R6 released, nothing latched", wake_o, 4'b0000);

    // R2/R3/R4/R5: window with a short pulse and a held line
    pulse_start();
    len = 0;
    while (keepout_o === 1'b1) begin
      len++;
      if (len == 100) wake_i[1] = 1'b1;
      if (len == 103) wake_i[1] = 1'b0;
      if (len == 500) wake_i[2] = 1'b1;
      if (len == 600) check("R3 blanked mid-window", wake_o, 4'b0000);
      tick();
      if (len > 3 * WIN) break;
    end
    check("R2 window length", 4'(len == WIN), 4'd1);
    check("R4/R5 released after window", wake_o, 4'b0110);

    // R7/R9: ack line 1 only
    pulse_ack(4'b0010);
    check("R7 ack clears line 1", wake_o, 4'b0100);
    check("R9 line 2 untouched", wake_o & 4'b0100, 4'b0100);
    wake_i[2] = 1'b0;
    tick(4);
    check("R4 line 2 held by latch", wake_o, 4'b0100);
    pulse_ack(4'b0100);
    check("R7 ack clears line 2", wake_o, 4'b0000);

    // R8: retrigger restarts the count
    pulse_start();
    tick(600);
    pulse_start();
    len = 0;
    while (keepout_o === 1'b1) begin
      len++;
      tick();
      if (len > 3 * WIN) break;
    end
    check("R8 restart length", 4'(len == WIN), 4'd1);

    // R6: outside the window, an ack with a live input leaves output alone
    wake_i = 4'b1000;
    tick(4);
    pulse_ack(4'b1000);
    check("R6 unlatched line follows input", wake_o, 4'b1000);
    wake_i = '0;
    tick(4);
    check("R6 idle again", wake_o, 4'b0000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule